// File: doc/BRIEF.md
# SDRAM Mode Register Load Guard

This block sits on the command side of a DDR2-style SDRAM model. It receives decoded commands and tracks which banks are open and whether a read or write burst is still running. From that state it decides whether a request to load the mode register is allowed. A load that is allowed overwrites the whole mode register in one step and then starts a lockout window. During that window every further command is refused.

A load request made while any bank is open, or while a burst is running, is illegal. The block refuses it with a one-cycle error pulse and leaves the register unchanged. The DLL-reset bit (bit 8) clears itself one cycle after it is loaded as 1, and a pulse output marks that cycle. The burst-length field (bits 2:0) is brought out on its own port, because reads and writes both use it.

All outputs are registered. A command presented in one cycle shows its effect on the outputs right after the next rising clock edge.

Top module: `mrs_cmd_guard`

## Requirements
- R1: A load request made while any bit of `bank_open` is 1 is refused. `load_err` is 1 for exactly one cycle and `mode_reg` does not change.
- R2: A load request made while `burst_busy` is 1 is refused in the same way: a one-cycle `load_err` pulse and no change to `mode_reg`.
- R3: An accepted load writes all MR_W bits of `cmd_data` into `mode_reg`, whatever the previous contents were.
- R4: For the TMRD cycles after an accepted load, `lock_busy` is 1. Any command presented in those cycles has no effect and produces a one-cycle `cmd_blocked` pulse. A command presented TMRD+1 cycles after the load is accepted.
- R5: When bit 8 is loaded as 1, `dll_reset_pulse` is 1 for the single cycle after the load, and after that cycle bit 8 of `mode_reg` reads 0. All other bits keep their values.
- R6: `burst_len` always equals bits 2:0 of `mode_reg`.
- R7: Activate (code 2) sets `bank_open[cmd_bank]`. Precharge-all (code 3) clears every bit of `bank_open`.
- R8: Read (code 4) or write (code 5) sets `burst_busy`. `burst_done` clears it. If both happen in the same cycle, the set wins.
- R9: After reset, `mode_reg`, `bank_open`, `burst_busy`, `lock_busy`, `load_err`, `cmd_blocked` and `dll_reset_pulse` are all 0.
- R10: Command codes on `cmd_op`: 0 = none, 1 = load mode, 2 = activate, 3 = precharge-all, 4 = read, 5 = write. Codes 6 and 7, and any code with `cmd_valid` low, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R10) |
| cmd_bank | input | BANK_W | Target bank for activate |
| cmd_data | input | MR_W | Value for a load command |
| burst_done | input | 1 | The running burst has finished |
| mode_reg | output | MR_W | Stored mode register |
| burst_len | output | 3 | Burst-length field of the register |
| bank_open | output | BANKS | Open flag for each bank |
| burst_busy | output | 1 | A burst is in progress |
| lock_busy | output | 1 | Post-load lockout window is active |
| cmd_blocked | output | 1 | A command was refused because of the lockout |
| load_err | output | 1 | An illegal load request was refused |
| dll_reset_pulse | output | 1 | Bit 8 is self-clearing this cycle |

## Verification
All state is brought out on the ports, so a wrong bank flag, burst flag or lockout count shows up on the next cycle. It appears directly on `bank_open`, `burst_busy` or `lock_busy`. It also shows indirectly, as a load that is accepted or refused when it should not be, or a command that is wrongly blocked. The bench drives the same stimulus into a cycle-level model and compares every output after every edge, so a divergence is reported in the cycle where it first appears. A self-clear of bit 8 that is missing or late is seen one cycle after the load, on both `mode_reg` and `dll_reset_pulse`.

// File: rtl/mrs_pkg.sv
// Shared command codes and constants for the mode register load guard.
package mrs_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ACT   = 3'd2,
        OP_PREA  = 3'd3,
        OP_READ  = 3'd4,
        OP_WRITE = 3'd5
    } cmd_op_e;

    // Position of the self-clearing DLL-reset bit in the mode register.
    localparam int DLL_BIT = 8;
    // Width of the burst-length field at the bottom of the register.
    localparam int BL_W    = 3;
endpackage

// File: rtl/mrs_bank_tracker.sv
// Tracks the open/idle flag of each bank and the burst-in-progress flag.
// Assumes: all inputs are qualified pulses; precharge-all takes priority
// over activate when both are given in the same cycle.
module mrs_bank_tracker #(
    parameter int BANKS  = 8,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_go,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              prea_go,
    input  logic              rw_go,
    input  logic              done_in,
    output logic [BANKS-1:0]  open_q,
    output logic              busy_q
);
    // Bank flags: precharge-all clears every bank, activate opens one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else if (prea_go) begin
            open_q <= '0;
        end else if (act_go) begin
            open_q[act_bank] <= 1'b1;
        end
    end

    // Burst flag: read/write sets it; burst completion clears it; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (rw_go) begin
            busy_q <= 1'b1;
        end else if (done_in) begin
            busy_q <= 1'b0;
        end
    end

    // R7: after a precharge-all no bank is open
    a_r7_prea_idles_all: assert property (@(posedge clk) disable iff (!rst_n)
        prea_go |=> (open_q == '0));
    // R8: completion without a new burst leaves the flag low
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_in && !rw_go) |=> !busy_q);
endmodule

// File: rtl/mrs_lockout.sv
// Down-counter that holds off commands for TMRD cycles after a load.
// Assumes: TMRD >= 1; start is only given while the counter is at zero.
module mrs_lockout #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(TMRD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Counter: reload on start, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(TMRD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R4: the count never exceeds the programmed window
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TMRD));
    // R4: a load always opens the window on the next cycle
    a_r4_start_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/mrs_mode_store.sv
// Holds the mode register; the DLL-reset bit clears itself one cycle after
// it is loaded as 1, with a pulse marking that cycle.
// Assumes: no write arrives in the cycle after a write (the lockout ensures it).
module mrs_mode_store #(
    parameter int MR_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [MR_W-1:0] wr_data,
    output logic [MR_W-1:0] mode_q,
    output logic            dll_pulse_q
);
    import mrs_pkg::*;

    // Register contents: full overwrite on a write, else self-clear bit 8.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data;
        end else if (dll_pulse_q) begin
            mode_q[DLL_BIT] <= 1'b0;
        end
    end

    // Pulse flag: marks the one cycle in which the loaded bit 8 is still set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_pulse_q <= 1'b0;
        end else begin
            dll_pulse_q <= wr_en && wr_data[DLL_BIT];
        end
    end

    // R5: the pulse lasts one cycle and bit 8 is clear afterwards
    a_r5_dll_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_pulse_q && !wr_en) |=> (!dll_pulse_q && !mode_q[DLL_BIT]));
    // R3: a write is seen in full on the next cycle
    a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == $past(wr_data)));
endmodule

// File: rtl/mrs_cmd_guard.sv
// Mode register load guard: decodes commands, refuses loads while a bank is
// open or a burst runs, writes the whole register on a legal load, and then
// blocks all commands for TMRD cycles.
// Assumes: commands are already decoded; TMRD >= 1; MR_W > 8.
module mrs_cmd_guard #(
    parameter int BANKS = 8,
    parameter int MR_W  = 14,
    parameter int TMRD  = 2,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [BANK_W-1:0]       cmd_bank,
    input  logic [MR_W-1:0]         cmd_data,
    input  logic                    burst_done,
    output logic [MR_W-1:0]         mode_reg,
    output logic [mrs_pkg::BL_W-1:0] burst_len,
    output logic [BANKS-1:0]        bank_open,
    output logic                    burst_busy,
    output logic                    lock_busy,
    output logic                    cmd_blocked,
    output logic                    load_err,
    output logic                    dll_reset_pulse
);
    import mrs_pkg::*;

    cmd_op_e op;
    logic    cmd_live, go, load_req, load_ok, load_bad;
    logic    act_go, prea_go, rw_go;

    // Command decode: a live command is a known nonzero code with valid high.
    always_comb begin
        op       = cmd_op_e'(cmd_op);
        cmd_live = cmd_valid && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
        go       = cmd_live && !lock_busy;
        load_req = go && (op == OP_LOAD);
        load_ok  = load_req && (bank_open == '0) && !burst_busy;
        load_bad = load_req && !load_ok;
        act_go   = go && (op == OP_ACT);
        prea_go  = go && (op == OP_PREA);
        rw_go    = go && ((op == OP_READ) || (op == OP_WRITE));
    end

    mrs_bank_tracker #(.BANKS(BANKS), .BANK_W(BANK_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_go   (act_go),
        .act_bank (cmd_bank),
        .prea_go  (prea_go),
        .rw_go    (rw_go),
        .done_in  (burst_done),
        .open_q   (bank_open),
        .busy_q   (burst_busy)
    );

    mrs_lockout #(.TMRD(TMRD)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (load_ok),
        .busy  (lock_busy)
    );

    mrs_mode_store #(.MR_W(MR_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (load_ok),
        .wr_data     (cmd_data),
        .mode_q      (mode_reg),
        .dll_pulse_q (dll_reset_pulse)
    );

    // Status pulses: refused loads and commands refused by the lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_err    <= 1'b0;
            cmd_blocked <= 1'b0;
        end else begin
            load_err    <= load_bad;
            cmd_blocked <= cmd_live && lock_busy;
        end
    end

    assign burst_len = mode_reg[BL_W-1:0];

    // R1/R2: a refused load leaves the register as it was
    a_r1_err_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> $stable(mode_reg));
    // R1/R2: the register changes by a load only from an idle, burst-free state
    a_r2_update_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_reg) && !$past(dll_reset_pulse)) |->
            (($past(bank_open) == '0) && !$past(burst_busy)));
    // R4: a blocked pulse only follows a cycle in the lockout window
    a_r4_block_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_blocked |-> $past(lock_busy));
    // R4: an error and a block never report the same command
    a_r4_err_or_block: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_err && cmd_blocked));
endmodule

// File: tb/mrs_cmd_guard_bench.sv
// Bench for the mode register load guard: a fixed-seed random mix plus
// directed corner cases, compared each cycle against a bench model.
module mrs_cmd_guard_bench;
    localparam int BANKS = 8;
    localparam int MR_W  = 14;
    localparam int TMRD  = 2;
    localparam int BW    = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_valid;
    logic [2:0]      cmd_op;
    logic [BW-1:0]   cmd_bank;
    logic [MR_W-1:0] cmd_data;
    logic            burst_done;
    logic [MR_W-1:0] mode_reg;
    logic [2:0]      burst_len;
    logic [BANKS-1:0] bank_open;
    logic            burst_busy, lock_busy, cmd_blocked, load_err, dll_reset_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [MR_W-1:0]  m_mr;
    logic [BANKS-1:0] m_banks;
    logic             m_busy, m_dll, m_blk, m_err;
    int               m_cnt;

    always #10 clk = ~clk;

    mrs_cmd_guard #(.BANKS(BANKS), .MR_W(MR_W), .TMRD(TMRD)) u_mrs_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_data(cmd_data), .burst_done(burst_done),
        .mode_reg(mode_reg), .burst_len(burst_len), .bank_open(bank_open),
        .burst_busy(burst_busy), .lock_busy(lock_busy), .cmd_blocked(cmd_blocked),
        .load_err(load_err), .dll_reset_pulse(dll_reset_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 mode_reg", 32'(mode_reg), 32'(m_mr));
        check("R6 burst_len", 32'(burst_len), 32'(m_mr[2:0]));
        check("R7 bank_open", 32'(bank_open), 32'(m_banks));
        check("R8 burst_busy", 32'(burst_busy), 32'(m_busy));
        check("R4 lock_busy", 32'(lock_busy), 32'(m_cnt != 0));
        check("R4 cmd_blocked", 32'(cmd_blocked), 32'(m_blk));
        check("R1/R2 load_err", 32'(load_err), 32'(m_err));
        check("R5 dll_reset_pulse", 32'(dll_reset_pulse), 32'(m_dll));
    endtask

    // Model one clock edge from the requirements, given the current inputs.
    task automatic model_edge();
        logic [MR_W-1:0]  n_mr = m_mr;
        logic [BANKS-1:0] n_banks = m_banks;
        logic             n_busy = m_busy;
        logic             n_dll = 1'b0;
        int               n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
        logic             live = cmd_valid && cmd_op >= 3'd1 && cmd_op <= 3'd5;
        m_blk = 1'b0;
        m_err = 1'b0;
        if (m_dll) n_mr[8] = 1'b0;
        if (burst_done) n_busy = 1'b0;
        if (live) begin
            if (m_cnt != 0) m_blk = 1'b1;
            else case (cmd_op)
                3'd1: if (m_banks == '0 && !m_busy) begin
                          n_mr = cmd_data; n_dll = cmd_data[8]; n_cnt = TMRD;
                      end else m_err = 1'b1;
                3'd2: n_banks[cmd_bank] = 1'b1;
                3'd3: n_banks = '0;
                default: n_busy = 1'b1;
            endcase
        end
        m_mr = n_mr; m_banks = n_banks; m_busy = n_busy; m_dll = n_dll; m_cnt = n_cnt;
    endtask

    // Drive one cycle of inputs at the falling edge, then check at the next one.
    task automatic step(input logic v, input logic [2:0] op, input logic [BW-1:0] b,
                        input logic [MR_W-1:0] d, input logic bd);
        cmd_valid = v; cmd_op = op; cmd_bank = b; cmd_data = d; burst_done = bd;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0;
        cmd_data = '0; burst_done = 1'b0;
        m_mr = '0; m_banks = '0; m_busy = 1'b0; m_dll = 1'b0;
        m_blk = 1'b0; m_err = 1'b0; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        compare_all();
        rst_n = 1'b1;
        idle(2);

        // R3/R5: legal load with bit 8 set, self-clear next cycle
        step(1'b1, 3'd1, '0, 14'h3FFF, 1'b0);
        check("R5 bit8 set right after load", 32'(mode_reg[8]), 32'd1);
        // R4: commands inside the TMRD window are blocked
        step(1'b1, 3'd2, 3'd5, '0, 1'b0);
        check("R5 bit8 cleared", 32'(mode_reg[8]), 32'd0);
        step(1'b1, 3'd2, 3'd5, '0, 1'b0);
        check("R4 activate blocked in window", 32'(bank_open), 32'd0);
        // R4: first cycle after the window is accepted
        step(1'b1, 3'd2, 3'd5, '0, 1'b0);
        check("R4 activate after window", 32'(bank_open), 32'h20);
        // R1: load with an open bank is refused
        step(1'b1, 3'd1, '0, 14'h0012, 1'b0);
        check("R1 refused load", 32'(load_err), 32'd1);
        // R10: unused codes and invalid strobe do nothing
        step(1'b1, 3'd6, 3'd1, 14'h0001, 1'b0);
        step(1'b1, 3'd7, 3'd2, 14'h0001, 1'b0);
        step(1'b0, 3'd2, 3'd0, 14'h0001, 1'b0);
        check("R10 no effect", 32'(bank_open), 32'h20);
        // R7: precharge-all, then R8 burst, then R2 load during burst
        step(1'b1, 3'd3, '0, '0, 1'b0);
        step(1'b1, 3'd4, '0, '0, 1'b0);
        step(1'b1, 3'd1, '0, 14'h0003, 1'b0);
        check("R2 refused during burst", 32'(load_err), 32'd1);
        // R8: set wins over done in the same cycle
        step(1'b1, 3'd5, '0, '0, 1'b1);
        check("R8 set wins", 32'(burst_busy), 32'd1);
        step(1'b0, 3'd0, '0, '0, 1'b1);
        // R3/R6: load without bit 8, full overwrite and burst length field
        step(1'b1, 3'd1, '0, 14'h2A43, 1'b0);
        check("R6 burst_len", 32'(burst_len), 32'd3);
        check("R3 full value", 32'(mode_reg), 32'h2A43);
        idle(3);

        // Random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 16);
            logic [2:0] op;
            case (r)
                4, 5:    op = 3'd1;
                6, 7:    op = 3'd2;
                8, 9, 10: op = 3'd3;
                11:      op = 3'd4;
                12:      op = 3'd5;
                13:      op = 3'd6;
                default: op = 3'd0;
            endcase
            step(($urandom % 8) != 0, op, BW'($urandom % BANKS),
                 MR_W'($urandom), ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule